// File: doc/BRIEF.md
# Inline Data-to-Memory Write Engine

This block accepts method writes (a register index plus a 32-bit value) from a command stream and turns a sequence of data words into consecutive 32-bit memory stores. Every method write with a legal index lands in a small register file. Two indices also cause side effects. A write to the launch register rewinds a running word offset to zero. A write to the payload register issues one store of the written value to the programmed destination plus four bytes times the offset.

The offset advances when the memory side accepts a store. The command side is held off while a store waits on memory, so no payload word is lost. Only plain linear uploads with a zero destination origin are carried out. Any other configuration, or an index outside the register file, raises a one-cycle error pulse and produces no store.

Top module: `inline_store_engine`

## Requirements
- R1: After a synchronous active-low reset, `mem_valid` and `err_pulse` are low, `cmd_ready` is high, all registers are zero and the word offset is zero.
- R2: A payload write (index 0x6D) accepted at clock edge k, with linear mode on and the origin at zero, drives `mem_valid` high after edge k. It sets `mem_data` to the written value. It sets `mem_addr` to ({reg 0x62, reg 0x63} + 4*offset) mod 2^64, with the carry out of the low word going into the high word.
- R3: Each store accepted by memory (`mem_valid` and `mem_ready` both high) advances the offset by one word, so successive payload words go to successive 4-byte addresses.
- R4: An accepted write to the launch register (index 0x6C) sets the offset to zero. If a store completes in the same cycle, the clear wins.
- R5: Register roles: 0x62 holds the upper address word, 0x63 the lower address word, 0x69 z, 0x6A x, 0x6B y, 0x6C bit 0 linear mode, 0x6D payload. Every accepted write with an index below 0x7F stores its value at that index.
- R6: A payload write while linear mode is off produces no store. It pulses `err_pulse` for exactly the cycle after acceptance and leaves the offset unchanged.
- R7: A payload write while any of x, y or z is nonzero produces no store and pulses `err_pulse` for exactly the cycle after acceptance.
- R8: A method index of 0x7F or above stores nothing and has no side effect. It pulses `err_pulse` for the cycle after acceptance.
- R9: While `mem_valid` is high and `mem_ready` is low, `cmd_ready` is low, and `mem_addr`, `mem_data` and `mem_valid` hold their values.
- R10: Writes to the other stored registers (line length 0x60, line count 0x61, pitch and the size fields 0x64 to 0x68) do not change the address or data of later stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Method write present |
| cmd_ready | output | 1 | Engine can take a method write |
| cmd_method | input | 8 | Register index of the method write |
| cmd_value | input | 32 | Value of the method write |
| mem_valid | output | 1 | Store request pending |
| mem_ready | input | 1 | Memory accepts the pending store |
| mem_addr | output | 64 | Byte address of the store |
| mem_data | output | 32 | Word to store |
| err_pulse | output | 1 | One-cycle flag for a rejected method write |

## Verification
A stuck or miscounted offset shows up as a wrong `mem_addr` on the very next store after the fault. A launch write that fails to rewind shows up on the first store after the launch write. A lost or duplicated store shows up as a `mem_valid` mismatch one cycle after the payload write, or as a `cmd_ready` mismatch during backpressure. A corrupted configuration register shows up only when it is next used: the address words in the next store address, and the linear and origin fields as an unexpected or missing error pulse. The reference model therefore compares every output on every cycle, so the first divergence is reported in the cycle it appears.

// File: rtl/ise_pkg.sv
// Shared types for the inline store engine.
// Assumes: the class is formed from one accepted method write per cycle.
package ise_pkg;

    typedef enum logic [2:0] {
        CLS_NONE,     // nothing accepted this cycle
        CLS_REG,      // plain register write, storage only
        CLS_LAUNCH,   // launch register write, rewinds the offset
        CLS_STORE,    // payload write that issues a store
        CLS_BAD_CFG,  // payload write refused by the configuration
        CLS_BAD_IDX   // index outside the register file
    } cmd_class_e;

endpackage

// File: rtl/ise_decode.sv
// Classifies the method write accepted this cycle.
// Assumes: linear and origin_zero reflect the registers before this write.
module ise_decode #(
    parameter int MW        = 8,
    parameter int NUM_REGS  = 127,
    parameter int LAUNCH_IX = 'h6C,
    parameter int DATA_IX   = 'h6D
) (
    input  logic                    accept,
    input  logic [MW-1:0]           method,
    input  logic                    linear,
    input  logic                    origin_zero,
    output ise_pkg::cmd_class_e     cls
);
    import ise_pkg::*;

    // Purpose: map index and configuration state to one command class.
    always_comb begin
        cls = CLS_NONE;
        if (accept) begin
            if (32'(method) >= NUM_REGS)
                cls = CLS_BAD_IDX;
            else if (32'(method) == LAUNCH_IX)
                cls = CLS_LAUNCH;
            else if (32'(method) == DATA_IX)
                cls = (linear && origin_zero) ? CLS_STORE : CLS_BAD_CFG;
            else
                cls = CLS_REG;
        end
    end
endmodule

// File: rtl/ise_regfile.sv
// Method-indexed register file; exposes only the fields the engine uses.
// Assumes: at most one write per cycle and an index already range-checked.
module ise_regfile #(
    parameter int MW        = 8,
    parameter int DW        = 32,
    parameter int NUM_REGS  = 127,
    parameter int ADDR_HI   = 'h62,
    parameter int ADDR_LO   = 'h63,
    parameter int ORG_Z     = 'h69,
    parameter int ORG_X     = 'h6A,
    parameter int ORG_Y     = 'h6B,
    parameter int LAUNCH_IX = 'h6C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [MW-1:0]   widx,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] base_addr,
    output logic            linear,
    output logic            origin_zero
);
    logic [DW-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Purpose: hold one register, written when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (32'(widx) == g))
                regs[g] <= wdata;
        end
    end

    // Purpose: present the destination and mode fields.
    always_comb begin
        base_addr   = {regs[ADDR_HI], regs[ADDR_LO]};
        linear      = regs[LAUNCH_IX][0];
        origin_zero = (regs[ORG_X] == '0) && (regs[ORG_Y] == '0) && (regs[ORG_Z] == '0);
    end
endmodule

// File: rtl/ise_offset.sv
// Running word offset: cleared by a launch write, advanced by each completed store.
// Assumes: clear has priority over advance in the same cycle.
module ise_offset #(
    parameter int OFF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [OFF_W-1:0] offset_q
);
    // Purpose: update the offset counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            offset_q <= '0;
        else if (clear)
            offset_q <= '0;
        else if (advance)
            offset_q <= offset_q + 1'b1;
    end
endmodule

// File: rtl/ise_store_port.sv
// One-entry store request register with valid/ready handshake.
// Assumes: load is only raised when the entry is empty or leaving this cycle.
module ise_store_port #(
    parameter int AW = 64,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);
    // Purpose: capture a new store or retire the accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
        end else if (load) begin
            mem_valid <= 1'b1;
            mem_addr  <= load_addr;
            mem_data  <= load_data;
        end else if (mem_ready) begin
            mem_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/inline_store_engine.sv
// Top: turns payload method writes into consecutive word stores.
// Assumes: memory holds mem_ready meaningful only while mem_valid is high.
module inline_store_engine #(
    parameter int MW        = 8,
    parameter int DW        = 32,
    parameter int AW        = 64,
    parameter int OFF_W     = 32,
    parameter int NUM_REGS  = 127,
    parameter int LAUNCH_IX = 'h6C,
    parameter int DATA_IX   = 'h6D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [MW-1:0] cmd_method,
    input  logic [DW-1:0] cmd_value,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic          err_pulse
);
    import ise_pkg::*;

    localparam int BYTE_SH = $clog2(DW / 8);
    localparam int PAD_W   = AW - OFF_W - BYTE_SH;

    logic             accept;
    logic             fire;
    cmd_class_e       cls;
    logic [AW-1:0]    base_addr;
    logic             dest_linear;
    logic             dest_origin_zero;
    logic [OFF_W-1:0] offset_q;
    logic [OFF_W-1:0] issue_off;
    logic [AW-1:0]    issue_addr;
    logic             err_q;

    // Purpose: handshake terms for both sides.
    always_comb begin
        fire      = mem_valid && mem_ready;
        cmd_ready = !mem_valid || mem_ready;
        accept    = cmd_valid && cmd_ready;
    end

    ise_decode #(
        .MW(MW), .NUM_REGS(NUM_REGS), .LAUNCH_IX(LAUNCH_IX), .DATA_IX(DATA_IX)
    ) u_decode (
        .accept(accept), .method(cmd_method), .linear(dest_linear),
        .origin_zero(dest_origin_zero), .cls(cls)
    );

    ise_regfile #(
        .MW(MW), .DW(DW), .NUM_REGS(NUM_REGS), .LAUNCH_IX(LAUNCH_IX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we((cls != CLS_NONE) && (cls != CLS_BAD_IDX)),
        .widx(cmd_method), .wdata(cmd_value),
        .base_addr(base_addr), .linear(dest_linear), .origin_zero(dest_origin_zero)
    );

    ise_offset #(.OFF_W(OFF_W)) u_offset (
        .clk(clk), .rst_n(rst_n), .clear(cls == CLS_LAUNCH),
        .advance(fire), .offset_q(offset_q)
    );

    // Purpose: address of a store issued now, counting a store completing now.
    always_comb begin
        issue_off  = offset_q + {{(OFF_W-1){1'b0}}, fire};
        issue_addr = base_addr + {{PAD_W{1'b0}}, issue_off, {BYTE_SH{1'b0}}};
    end

    ise_store_port #(.AW(AW), .DW(DW)) u_port (
        .clk(clk), .rst_n(rst_n), .load(cls == CLS_STORE),
        .load_addr(issue_addr), .load_data(cmd_value), .mem_ready(mem_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    // Purpose: one-cycle flag for refused method writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= (cls == CLS_BAD_IDX) || (cls == CLS_BAD_CFG);
    end

    assign err_pulse = err_q;
endmodule

// File: rtl/ise_checker.sv
// Temporal properties of the inline store engine, bound to the top module.
module ise_checker #(
    parameter int MW        = 8,
    parameter int DW        = 32,
    parameter int AW        = 64,
    parameter int OFF_W     = 32,
    parameter int NUM_REGS  = 127,
    parameter int LAUNCH_IX = 'h6C,
    parameter int DATA_IX   = 'h6D
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [MW-1:0]    cmd_method,
    input logic [DW-1:0]    cmd_value,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [AW-1:0]    mem_addr,
    input logic [DW-1:0]    mem_data,
    input logic             err_pulse,
    input logic [OFF_W-1:0] offset_q,
    input logic             linear,
    input logic             origin_zero
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R9
    AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && 32'(cmd_method) == DATA_IX && linear && origin_zero)
        |=> (mem_valid && mem_data == $past(cmd_value) && !err_pulse)); // R2
    AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !(acc && 32'(cmd_method) == LAUNCH_IX))
        |=> (offset_q == $past(offset_q) + 1'b1)); // R3
    AST_LAUNCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && 32'(cmd_method) == LAUNCH_IX) |=> (offset_q == '0)); // R4
    AST_NONLINEAR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && 32'(cmd_method) == DATA_IX && !linear) |=> (err_pulse && !mem_valid)); // R6
    AST_ORIGIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && 32'(cmd_method) == DATA_IX && !origin_zero) |=> (err_pulse && !mem_valid)); // R7
    AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && 32'(cmd_method) >= NUM_REGS) |=> (err_pulse && !mem_valid)); // R8
endmodule

bind inline_store_engine ise_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_method(cmd_method), .cmd_value(cmd_value), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .err_pulse(err_pulse), .offset_q(offset_q), .linear(dest_linear),
    .origin_zero(dest_origin_zero)
);

// File: tb/inline_store_engine_bench.sv
module inline_store_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_method = '0;
    logic [31:0] cmd_value = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [63:0] mem_addr;
    logic [31:0] mem_data;
    logic        err_pulse;

    int compared = 0;
    int mismatched = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    inline_store_engine u_inline_store_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_method(cmd_method), .cmd_value(cmd_value), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .err_pulse(err_pulse)
    );

    // Behavioural reference model
    logic [31:0] m_regs [127];
    logic        m_valid;
    logic [63:0] m_addr;
    logic [31:0] m_data;
    logic        m_err;
    logic [31:0] m_off;

    always @(posedge clk) begin
        bit fire;
        bit acc;
        if (!rst_n) begin
            for (int i = 0; i < 127; i++) m_regs[i] = '0;
            m_valid = 0; m_addr = '0; m_data = '0; m_err = 0; m_off = '0;
        end else begin
            fire = m_valid && mem_ready;
            acc  = cmd_valid && (!m_valid || mem_ready);
            m_err = 0;
            if (fire) begin m_off = m_off + 1; m_valid = 0; end
            if (acc) begin
                if (cmd_method >= 8'd127) m_err = 1;
                else begin
                    if (cmd_method == 8'h6D) begin
                        if (!m_regs['h6C][0] || (m_regs['h69] | m_regs['h6A] | m_regs['h6B]) != 0)
                            m_err = 1;
                        else begin
                            m_valid = 1;
                            m_addr = {m_regs['h62], m_regs['h63]} + {30'd0, m_off, 2'b00};
                            m_data = cmd_value;
                        end
                    end
                    m_regs[cmd_method] = cmd_value;
                    if (cmd_method == 8'h6C) m_off = '0;
                end
            end
        end
    end

    task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s got %h expected %h", cur_req, what, got, exp);
        end
    endtask

    // Compare every output once per cycle, away from the active edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check("mem_valid", 64'(mem_valid), 64'(m_valid));
            check("err_pulse", 64'(err_pulse), 64'(m_err));
            check("cmd_ready", 64'(cmd_ready), 64'(!m_valid || mem_ready));
            if (m_valid) begin
                check("mem_addr", mem_addr, m_addr);
                check("mem_data", 64'(mem_data), 64'(m_data));
            end
        end
    end

    task automatic send(input logic [7:0] m, input logic [31:0] v);
        bit rdy;
        cmd_valid = 1; cmd_method = m; cmd_value = v;
        forever begin
            rdy = cmd_ready;
            @(posedge clk);
            if (rdy) break;
        end
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        cmd_valid = 0;
        repeat (n) begin @(negedge clk); #1; end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        chk_en = 1;
        @(negedge clk); #1;
        rst_n = 1;
        cur_req = "R1";
        idle(2);

        cur_req = "R5";
        send(8'h62, 32'h0000_0001);
        send(8'h63, 32'h1000_0000);
        send(8'h6C, 32'h1);
        cur_req = "R2";
        send(8'h6D, 32'hA0A0_0001);
        cur_req = "R3";
        send(8'h6D, 32'hA0A0_0002);
        send(8'h6D, 32'hA0A0_0003);
        idle(2);

        cur_req = "R9";
        mem_ready = 0;
        send(8'h6D, 32'hB0B0_0001);
        fork
            send(8'h6D, 32'hB0B0_0002);
            begin repeat (4) begin @(negedge clk); #1; end mem_ready = 1; end
        join
        idle(1);
        mem_ready = 0;
        idle(3);
        mem_ready = 1;
        idle(2);

        cur_req = "R4";
        send(8'h6C, 32'h1);
        send(8'h6D, 32'hC0C0_0001);
        send(8'h6C, 32'h1);
        send(8'h6D, 32'hC0C0_0002);
        idle(2);

        cur_req = "R6";
        send(8'h6C, 32'h0);
        send(8'h6D, 32'hD0D0_0001);
        idle(1);
        send(8'h6C, 32'h1);
        send(8'h6D, 32'hD0D0_0002);
        idle(1);

        cur_req = "R7";
        send(8'h6A, 32'h5);
        send(8'h6D, 32'hE0E0_0001);
        send(8'h6A, 32'h0);
        send(8'h69, 32'h1);
        send(8'h6D, 32'hE0E0_0002);
        send(8'h69, 32'h0);
        send(8'h6B, 32'h3);
        send(8'h6D, 32'hE0E0_0003);
        send(8'h6B, 32'h0);
        send(8'h6D, 32'hE0E0_0004);
        idle(1);

        cur_req = "R8";
        send(8'h7F, 32'hFFFF_FFFF);
        send(8'hFF, 32'h0);
        send(8'h6D, 32'hF0F0_0001);
        idle(1);

        cur_req = "R10";
        send(8'h60, 32'h40);
        send(8'h61, 32'h8);
        send(8'h64, 32'h100);
        send(8'h66, 32'h77);
        send(8'h6D, 32'h1234_5678);
        idle(1);

        cur_req = "R2";
        send(8'h63, 32'hFFFF_FFFC);
        send(8'h6C, 32'h1);
        send(8'h6D, 32'h5555_0001);
        send(8'h6D, 32'h5555_0002);
        idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog R1 got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule